// File: doc/BRIEF.md
# Counterflow Systolic Convolution Array

This block computes a K-tap sliding convolution with a row of K identical cells that talk only to their immediate neighbours. Each cell holds one coefficient that is written through a small load port and then stays in place. Input samples enter at the left end and move one cell to the right per clock. Partial sums start as zero at the right end and move one cell to the left per clock. Each time a partial sum passes a cell, it adds that cell's coefficient times the sample it meets there. Finished results leave at the left end, next to where samples enter. No wire spans the array, and no result bus gathers outputs from the cells.

Samples and sums travel in opposite directions, so the array runs in a two-cycle rhythm. A sample is accepted at most every other clock. A result is valid only when the partial sum met an accepted sample in every cell. A valid flag travels with each partial sum, and each cell clears it when the sample passing that cell is empty. A result is available one cycle after the last sample it needs has been presented, however long the array is.

Coefficient m (m = 0 is the coefficient applied to the oldest sample of a window) is written by presenting index m on the load port. The sum is signed two's complement and is 2·DW + clog2(K) bits wide.

Top module: `scv_conv_array`

## Requirements
- R1: While reset is held, and in the cycles after it before any sample is accepted, `y_valid` is 0 and `y_data` is 0.
- R2: Suppose samples are accepted at clock edges c0, c0−2, …, c0−2(K−1). Then after edge c0, `y_valid` is 1 and `y_data` = Σ over m = 0..K−1 of coef[m] · x(c0 − 2(K−1−m)), where x(e) is the sample accepted at edge e.
- R3: The result is `2*DW + clog2(K)` bits wide and cannot overflow. With every coefficient and sample at the most negative value, the output is the exact positive product sum, and every valid result lies within ±K·2^(2·DW−2).
- R4: After any edge where the condition of R2 does not hold, `y_valid` is 0. This covers the start of a stream and any window with a missing sample or a gap longer than one cycle.
- R5: `x_valid` is ignored on a clock edge that directly follows an edge where a sample was accepted. Such a sample contributes to no result, and the next accepted sample may follow it at once.
- R6: When `w_load` is 1 at an edge, `w_data` becomes coefficient `w_idx` (0 = oldest-sample tap, K−1 = newest-sample tap). Results whose window starts after the load use the new value. Coefficients hold when `w_load` is 0.
- R7: A result is presented on the clock edge that accepts the newest sample of its window. The output is therefore available one cycle after that sample was driven, independent of K.
- R8: Samples, coefficients and results are signed two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_load | input | 1 | Write one coefficient this cycle |
| w_idx | input | IW = max(1, clog2(K)) | Coefficient index, 0 = oldest-sample tap |
| w_data | input | DW | Signed coefficient value |
| x_valid | input | 1 | A sample is offered this cycle |
| x_data | input | DW | Signed sample value |
| y_valid | output | 1 | `y_data` holds a finished result |
| y_data | output | 2·DW + clog2(K) | Signed result |

## Verification
The bench builds the array with K = 4 and DW = 4, which gives a 10-bit result. At this size, every sample value from −8 to 7 can be streamed through several coefficient sets, including the all-minimum corner that produces the largest positive sum. A reference model tracks which edges accepted a sample. From that record it predicts validity and value on every cycle. This covers start-up windows, gaps of two or more cycles, and bursts in which `x_valid` stays high so that every second offer is dropped.

// File: rtl/scv_pkg.sv
package scv_pkg;

    // Result width that holds K products of two DW-bit signed values.
    function automatic int acc_bits(input int dw, input int k);
        return 2 * dw + $clog2(k);
    endfunction

    // Width of a coefficient index.
    function automatic int idx_bits(input int k);
        return (k > 1) ? $clog2(k) : 1;
    endfunction

endpackage

// File: rtl/scv_admit.sv
module scv_admit #(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 x_valid,
    input  logic signed [DW-1:0] x_data,
    output logic                 acc_v,
    output logic signed [DW-1:0] acc_x
);
    typedef struct packed {
        logic last;
    } admit_t;

    admit_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        acc_v     = x_valid & ~st_q.last;
        acc_x     = acc_v ? x_data : '0;
        st_d.last = acc_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: accepted samples never land on two consecutive edges
    p_two_cycle_rhythm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v |=> !acc_v);

endmodule

// File: rtl/scv_cell.sv
module scv_cell #(
    parameter int DW = 8,
    parameter int AW = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_ld,
    input  logic signed [DW-1:0] w_din,
    input  logic signed [DW-1:0] x_in,
    input  logic                 xv_in,
    input  logic signed [AW-1:0] y_in,
    input  logic                 yv_in,
    output logic signed [DW-1:0] x_out,
    output logic                 xv_out,
    output logic signed [AW-1:0] y_out,
    output logic                 yv_out
);
    typedef struct packed {
        logic signed [DW-1:0] coef;
        logic signed [DW-1:0] x;
        logic                 xv;
        logic signed [AW-1:0] y;
        logic                 yv;
    } cell_t;

    cell_t st_d, st_q;

    logic signed [AW-1:0] coef_ext;
    logic signed [AW-1:0] x_ext;
    logic signed [AW-1:0] prod;

    always_comb begin
        coef_ext = AW'(st_q.coef);
        x_ext    = AW'(x_in);
        prod     = coef_ext * x_ext;

        st_d      = st_q;
        st_d.x    = x_in;
        st_d.xv   = xv_in;
        st_d.y    = y_in + prod;
        st_d.yv   = yv_in & xv_in;
        if (w_ld) st_d.coef = w_din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_out  = st_q.x;
    assign xv_out = st_q.xv;
    assign y_out  = st_q.y;
    assign yv_out = st_q.yv;

    // R6: a coefficient written this edge is the one held afterwards
    p_coef_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_ld |=> st_q.coef == $past(w_din));
    // R6: no write, no change
    p_coef_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !w_ld |=> $stable(st_q.coef));
    // R4: a partial sum leaving valid must have met a real sample here
    p_token_needs_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        yv_out |-> $past(xv_in));

endmodule

// File: rtl/scv_conv_array.sv
module scv_conv_array #(
    parameter int DW = 8,
    parameter int K  = 8,
    localparam int IW = scv_pkg::idx_bits(K),
    localparam int AW = scv_pkg::acc_bits(DW, K)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_load,
    input  logic [IW-1:0]        w_idx,
    input  logic signed [DW-1:0] w_data,
    input  logic                 x_valid,
    input  logic signed [DW-1:0] x_data,
    output logic                 y_valid,
    output logic signed [AW-1:0] y_data
);
    localparam longint BOUND = longint'(K) <<< (2 * DW - 2);

    logic signed [DW-1:0] xs  [0:K];
    logic                 xvs [0:K];
    logic signed [AW-1:0] ys  [0:K];
    logic                 yvs [0:K];

    scv_admit #(.DW(DW)) u_admit (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_valid (x_valid),
        .x_data  (x_data),
        .acc_v   (xvs[0]),
        .acc_x   (xs[0])
    );

    // Partial sums enter at the far end as zero with a valid token set.
    assign ys[K]  = '0;
    assign yvs[K] = 1'b1;

    // Cell j holds coefficient index K-1-j: the newest-sample tap sits
    // next to the input, the oldest-sample tap at the far end.
    for (genvar j = 0; j < K; j++) begin : g_cell
        logic ld_here;
        assign ld_here = w_load && (32'(w_idx) == 32'(K - 1 - j));

        scv_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .w_ld   (ld_here),
            .w_din  (w_data),
            .x_in   (xs[j]),
            .xv_in  (xvs[j]),
            .y_in   (ys[j+1]),
            .yv_in  (yvs[j+1]),
            .x_out  (xs[j+1]),
            .xv_out (xvs[j+1]),
            .y_out  (ys[j]),
            .yv_out (yvs[j])
        );
    end

    assign y_valid = yvs[0];
    assign y_data  = ys[0];

    // R7: a result appears only on the edge that accepted a sample
    p_result_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> $past(xvs[0]));
    // R3: valid results stay inside the representable product-sum range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (longint'(y_data) <= BOUND && longint'(y_data) >= -BOUND));
    // R4: with an empty input this cycle, nothing valid follows
    p_empty_no_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !x_valid |=> !y_valid);

endmodule

// File: tb/sim_scv_conv_array.sv
module sim_scv_conv_array;
    localparam int CLK_P = 10;
    localparam int K     = 4;
    localparam int DW    = 4;
    localparam int IW    = 2;
    localparam int AW    = 2 * DW + 2;
    localparam int HMAX  = 4096;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic                 w_load = 0;
    logic [IW-1:0]        w_idx = '0;
    logic signed [DW-1:0] w_data = '0;
    logic                 x_valid = 0;
    logic signed [DW-1:0] x_data = '0;
    logic                 y_valid;
    logic signed [AW-1:0] y_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit prev_acc = 0;
    bit hv [0:HMAX-1];
    int hx [0:HMAX-1];
    int coef [0:K-1];
    string tag = "R1";

    always #(CLK_P/2) clk = ~clk;

    scv_conv_array #(.DW(DW), .K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_idx(w_idx),
        .w_data(w_data), .x_valid(x_valid), .x_data(x_data),
        .y_valid(y_valid), .y_data(y_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // One clock edge with the given offer; model predicts the outputs.
    task automatic step(input bit v, input int d);
        bit acc, need;
        int sum;
        @(negedge clk);
        x_valid = v;
        x_data  = DW'(d);
        @(posedge clk);
        acc = v && !prev_acc;          // R5: offer right after an accepted one is dropped
        prev_acc = acc;
        hv[cyc] = acc;
        hx[cyc] = d;
        need = 1;
        sum  = 0;
        for (int m = 0; m < K; m++) begin
            int c = cyc - 2 * (K - 1 - m);
            if (c < 0 || !hv[c]) need = 0;
            else sum += coef[m] * hx[c];
        end
        #1;
        // R2/R7 when a result is due, R4 otherwise
        check(need ? tag : "R4", int'(y_valid), int'(need));
        if (need) check(tag, int'(y_data), sum);
        cyc++;
    endtask

    task automatic load(input int m, input int val);
        @(negedge clk);
        w_load = 1; w_idx = IW'(m); w_data = DW'(val);
        @(posedge clk);
        coef[m] = val;
        #1;
        w_load = 0;
        // bookkeeping for the model: this edge had no sample
        prev_acc = 0; hv[cyc] = 0; hx[cyc] = 0; cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic load_set(input int a, input int b, input int c, input int d);
        idle(2 * K + 2);
        load(0, a); load(1, b); load(2, c); load(3, d);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < HMAX; i++) begin hv[i] = 0; hx[i] = 0; end
        for (int m = 0; m < K; m++) coef[m] = 0;

        // R1: outputs during reset
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(y_valid), 0);
        check("R1", int'(y_data), 0);
        @(negedge clk);
        rst_n = 1;
        tag = "R1";
        idle(3);

        // R6/R2/R7: distinct taps, ramp stream
        tag = "R6";
        load_set(1, 2, 3, 4);
        tag = "R2";
        for (int i = 0; i < 12; i++) begin step(1, i - 5); step(0, 0); end

        // R2/R8: sweep all sample values under several coefficient sets
        for (int s = 0; s < 4; s++) begin
            tag = "R6";
            case (s)
                0: load_set(-1, 3, -5, 7);
                1: load_set(7, -8, 0, 2);
                2: load_set(-3, -3, 4, 1);
                default: load_set(5, 0, -7, -2);
            endcase
            tag = "R8";
            for (int r = 0; r < 2; r++)
                for (int v = -8; v < 8; v++) begin
                    step(1, (r == 0) ? v : -1 - v);
                    step(0, 0);
                end
        end

        // R4: gaps longer than one cycle break windows
        tag = "R2";
        load_set(2, -1, 3, 1);
        tag = "R4";
        for (int i = 0; i < 6; i++) begin step(1, i); step(0, 0); end
        step(0, 0);
        for (int i = 0; i < 10; i++) begin step(1, 3 - i); step(0, 0); end
        step(1, 5); idle(3); step(1, 6); step(0, 0);

        // R5: held-high offers, every second one dropped
        tag = "R5";
        for (int i = 0; i < 20; i++) step(1, (i * 5) % 16 - 8);
        step(0, 0);
        for (int i = 0; i < 6; i++) begin step(1, 2); step(1, 7); step(1, -8); end

        // R3: extreme corners
        tag = "R3";
        load_set(-8, -8, -8, -8);
        tag = "R3";
        for (int i = 0; i < 8; i++) begin step(1, -8); step(0, 0); end
        load_set(7, 7, 7, 7);
        tag = "R3";
        for (int i = 0; i < 8; i++) begin step(1, -8); step(0, 0); end
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule